// File: doc/BRIEF.md
# SM3 Compression Round Engine

This block applies the SM3 compression function to one 512-bit message block. It works on a 256-bit chaining value, which it holds as eight 32-bit working words A (most significant) down to H (least significant). A one-cycle `start` pulse captures the chaining input. The engine then runs one round per clock for 64 rounds.

In each round the engine shows the current round number on `round_idx`. In that same cycle it reads two expanded message words: the plain word on `w_word` and the XOR-combined word on `wp_word`. The surrounding logic is responsible for padding and for message expansion. It supplies the word pair that matches the round number shown.

After the last round, each working word is XORed with the chaining word captured at start. The 256-bit outcome appears on `result`, and `done` pulses for one cycle. To hash a longer message, feed `result` back as the chaining input of the next block.

Top module: `sm3_round_core`

## Requirements
- R1: After reset, `done` is 0, `result` is all zeros and `round_idx` is 0.
- R2: A `start` sampled high while idle begins a run. During the cycle of round j (j = 0..63), `round_idx` reads j, beginning the cycle after the start edge. `done` is high for exactly one cycle, 64 rising edges after the edge that sampled `start`. Afterwards `round_idx` returns to 0.
- R3: Rounds 0 to 15 use x^y^z for both boolean functions. Their constant is 0x79cc4519 rotated left by j.
- R4: Rounds 16 to 63 use majority(A,B,C) for the first function and choose(E,F,G) for the second. Their constant is 0x7a879d8a rotated left by (j mod 32), so round 16 uses 0x9d8a7a87.
- R5: Each round computes the following, with all additions mod 2^32:
  - SS1 = rol(rol(A,12)+E+K,7) and SS2 = SS1^rol(A,12).
  - TT1 = FF+D+SS2+wp_word and TT2 = GG+H+SS1+w_word.
  - The words then shift: A←TT1, B←A, C←rol(B,9), D←C, E←P0(TT2), F←E, G←rol(F,19), H←G, where P0(x)=x^rol(x,9)^rol(x,17).
- R6: `result` is the final working state XORed word by word with the chaining value captured at start, with A in bits 255:224. It is not a modular sum.
- R7: Feeding `result` back as `chain_in` of the next block yields the multi-block hash of a message.
- R8: `start` asserted during a run has no effect. The running computation, its `result` and the count of `done` pulses are unchanged.
- R9: `result` changes only in the cycle in which `done` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin compressing a block (idle only) |
| chain_in | input | 256 | Incoming chaining value, A in bits 255:224 |
| w_word | input | 32 | Expanded message word for the round on `round_idx` |
| wp_word | input | 32 | XOR-combined message word for the same round |
| round_idx | output | 6 | Round currently executing |
| result | output | 256 | New chaining value |
| done | output | 1 | One-cycle pulse when `result` is fresh |

## Verification
The bound checker covers the control behaviour on every cycle:
- `done` lasts one cycle.
- `round_idx` steps by one through a run and rests at 0 when idle.
- A run is not disturbed by a second `start`.
- `result` moves only together with `done`.

The arithmetic can only be shown by scenarios that compare `result` against an independent model in the bench. That arithmetic covers the two boolean phases, the constant sequence, P0 and the final XOR. The scenarios include the known one-block and two-block digests, which show the chaining and the phase switch at round 16.

// File: rtl/sm3_round_core.sv
module sm3_round_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [255:0] chain_in,
  input  logic [31:0]  w_word,
  input  logic [31:0]  wp_word,
  output logic [5:0]   round_idx,
  output logic [255:0] result,
  output logic         done
);
  localparam logic [31:0] K_LO_BASE = 32'h79cc4519;
  localparam logic [31:0] K_HI_BASE = 32'h7a879d8a;
  localparam logic [31:0] K_HI_AT16 = {K_HI_BASE[15:0], K_HI_BASE[31:16]};
  localparam logic [5:0]  LAST_RND  = 6'd63;

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  logic         busy;
  logic [5:0]   rnd;
  logic [31:0]  kreg;
  logic [31:0]  a, b, c, d, e, f, g, h;
  logic [255:0] chain_q;

  logic         late;
  logic [31:0]  a12, ss1, ss2, ff, gg, tt1, tt2, p0;
  logic [255:0] nxt;

  assign late = rnd[5] | rnd[4];
  assign a12  = rol(a, 12);
  assign ss1  = rol(a12 + e + kreg, 7);
  assign ss2  = ss1 ^ a12;
  assign ff   = late ? ((a & b) | (a & c) | (b & c)) : (a ^ b ^ c);
  assign gg   = late ? ((e & f) | (~e & g)) : (e ^ f ^ g);
  assign tt1  = ff + d + ss2 + wp_word;
  assign tt2  = gg + h + ss1 + w_word;
  assign p0   = tt2 ^ rol(tt2, 9) ^ rol(tt2, 17);
  assign nxt  = {tt1, a, rol(b, 9), c, p0, e, rol(f, 19), g};

  assign round_idx = rnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rnd     <= '0;
      kreg    <= '0;
      chain_q <= '0;
      {a, b, c, d, e, f, g, h} <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          rnd     <= '0;
          kreg    <= K_LO_BASE;
          chain_q <= chain_in;
          {a, b, c, d, e, f, g, h} <= chain_in;
        end
      end else begin
        {a, b, c, d, e, f, g, h} <= nxt;
        kreg <= (rnd == 6'd15) ? K_HI_AT16 : rol(kreg, 1);
        if (rnd == LAST_RND) begin
          busy   <= 1'b0;
          rnd    <= '0;
          result <= nxt ^ chain_q;
          done   <= 1'b1;
        end else begin
          rnd <= rnd + 6'd1;
        end
      end
    end
  end
endmodule

module sm3_round_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic [5:0]   round_idx,
  input logic [255:0] result,
  input logic         done
);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && round_idx != 6'd63) |=> (round_idx == $past(round_idx) + 6'd1));

  // R2
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> round_idx == 6'd0);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && round_idx != 6'd63) |=> (busy && !done));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind sm3_round_core sm3_round_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .round_idx(round_idx), .result(result), .done(done)
);

// File: tb/test_sm3_round_core.sv
module test_sm3_round_core;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0;
  logic [255:0] chain_in = '0;
  logic [31:0]  w_word = '0, wp_word = '0;
  logic [5:0]   round_idx;
  logic [255:0] result;
  logic         done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [255:0] sbq[$];
  logic [31:0]  blk [16];
  logic [31:0]  cw  [68];
  logic [31:0]  cwp [64];
  logic [31:0]  seed = 32'h1234abcd;

  localparam logic [255:0] IV =
    256'h7380166f4914b2b9172442d7da8a0600a96f30bc163138aae38dee4db0fb0e4e;

  always #5 clk = ~clk;

  sm3_round_core i_sm3_round_core (.*);

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int m = n % 32;
    return (m == 0) ? x : ((x << m) | (x >> (32 - m)));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expand();
    for (int j = 0; j < 16; j++) cw[j] = blk[j];
    for (int j = 16; j < 68; j++) begin
      logic [31:0] t;
      t = cw[j-16] ^ cw[j-9] ^ rl(cw[j-3], 15);
      cw[j] = t ^ rl(t, 15) ^ rl(t, 23) ^ rl(cw[j-13], 7) ^ cw[j-6];
    end
    for (int j = 0; j < 64; j++) cwp[j] = cw[j] ^ cw[j+4];
  endtask

  // Reference for R3, R4, R5, R6
  function automatic logic [255:0] model(input logic [255:0] v);
    logic [31:0] A, B, C, D, E, F, G, H, k, s1, s2, f1, g1, t1, t2;
    {A, B, C, D, E, F, G, H} = v;
    for (int j = 0; j < 64; j++) begin
      k  = (j < 16) ? rl(32'h79cc4519, j) : rl(32'h7a879d8a, j);
      s1 = rl(rl(A, 12) + E + k, 7);
      s2 = s1 ^ rl(A, 12);
      f1 = (j < 16) ? (A ^ B ^ C) : ((A & B) | (A & C) | (B & C));
      g1 = (j < 16) ? (E ^ F ^ G) : ((E & F) | (~E & G));
      t1 = f1 + D + s2 + cwp[j];
      t2 = g1 + H + s1 + cw[j];
      D = C; C = rl(B, 9); B = A; A = t1;
      H = G; G = rl(F, 19); F = E; E = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    return {A, B, C, D, E, F, G, H} ^ v;
  endfunction

  // Driver: pushes the expected result, then serves the word pairs round by round
  task automatic run_block(input logic [255:0] chain, input bit poke_start);
    expand();
    sbq.push_back(model(chain));
    @(negedge clk);
    start = 1; chain_in = chain;
    @(negedge clk);
    start = 0;
    for (int j = 0; j < 64; j++) begin
      if (j == 0 || j == 15 || j == 16 || j == 63)
        chk(round_idx == j[5:0], "R2 round_idx", 256'(round_idx), 256'(j));
      if (poke_start && j == 30) begin start = 1; chain_in = ~chain; end
      if (poke_start && j == 31) begin start = 0; chain_in = chain; end
      w_word = cw[j]; wp_word = cwp[j];
      @(negedge clk);
    end
    chk(done === 1'b1, "R2 done timing", 256'(done), 256'd1);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) chk(0, "R8 unexpected done", 256'd1, 256'd0);
      else begin
        logic [255:0] e;
        e = sbq.pop_front();
        chk(result === e, "R5/R6 scoreboard", result, e);
      end
    end
  end

  task automatic rand_blk();
    for (int i = 0; i < 16; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      blk[i] = seed;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] r0, chain2;
    repeat (3) @(negedge clk);
    // R1
    chk(done === 1'b0, "R1 done", 256'(done), 256'd0);
    chk(result === '0, "R1 result", result, 256'd0);
    chk(round_idx === 6'd0, "R1 round_idx", 256'(round_idx), 256'd0);
    rst_n = 1;

    // R3 R4 R5 R6: known one-block digest of "abc"
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
    run_block(IV, 0);
    chk(result === 256'h66c7f0f462eeedd9d1f2d46bdc10e4e24167c4875cf2f7a2297da02b8f4ba8e0,
        "R6 abc digest", result,
        256'h66c7f0f462eeedd9d1f2d46bdc10e4e24167c4875cf2f7a2297da02b8f4ba8e0);

    // R9: done one cycle, result held
    r0 = result;
    @(negedge clk);
    chk(done === 1'b0, "R9 done single", 256'(done), 256'd0);
    repeat (5) @(negedge clk);
    chk(result === r0, "R9 result hold", result, r0);
    chk(round_idx === 6'd0, "R2 idle index", 256'(round_idx), 256'd0);

    // R7: two-block message of 64 bytes "abcd" repeated
    for (int i = 0; i < 16; i++) blk[i] = 32'h61626364;
    run_block(IV, 0);
    chain2 = result;
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[0] = 32'h80000000; blk[15] = 32'h00000200;
    run_block(chain2, 0);
    chk(result === 256'hdebe9ff92275b8a138604889c18e5a4d6fdb70e5387e5765293dcba39c0c5732,
        "R7 two-block digest", result,
        256'hdebe9ff92275b8a138604889c18e5a4d6fdb70e5387e5765293dcba39c0c5732);

    // R3 R4: all-zero block, all-ones chain
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    run_block({256{1'b1}}, 0);

    // R5: several pseudo-random blocks and chains, back to back
    for (int n = 0; n < 4; n++) begin
      rand_blk();
      run_block({seed, ~seed, seed ^ 32'h5a5a5a5a, seed + 32'd7, r0[127:0]}, 0);
    end

    // R8: start during a run is ignored
    rand_blk();
    run_block(IV ^ {8{seed}}, 1);
    repeat (70) @(negedge clk);
    chk(sbq.size() == 0, "R8 queue drained", 256'(sbq.size()), 256'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule